// File: doc/BRIEF.md
# Wide-Bus to Narrow-Port Width Down-Converter

This block is a Wishbone slave that serves every bus access through a memory command port whose data width is the same as, or a power-of-two fraction of, the bus width. Each bus word is handled as `RATIO = BUS_DW / PORT_DW` narrow commands at consecutive port addresses. On a write the latched bus word is cut into port-width slices. On a read the returned port words are collected into a holding register, and that register is presented on the bus read-data lines.

The incoming word address first has a byte-granular base offset removed, then it is scaled by the ratio. The lowest slice of the bus word always uses the lowest port address. A configuration whose port is wider than the bus, whose ratio is not a power of two, or whose port width is not a whole number of bytes stops elaboration.

The sequencer has four states.
- `ST_IDLE`: the transition *start* (`wb_cyc && wb_stb`) latches the request, clears the slice counter and moves to `ST_ISSUE`.
- `ST_ISSUE`: drives one command and waits there for `cmd_ready`. After a write handshake it takes *next slice* (stay in `ST_ISSUE`, counter +1) or *write done* (to `ST_ACK`). After a read handshake it takes *read issued* (to `ST_WAIT_RD`).
- `ST_WAIT_RD`: waits for `rd_valid` and stores the returned word. It then takes *read next* (back to `ST_ISSUE`, counter +1) or *read done* (to `ST_ACK`).
- `ST_ACK`: drives the acknowledge for one cycle and takes *release* back to `ST_IDLE`.

Top module: `wb_narrow_bridge`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequence, `wb_ack` and `cmd_valid` are 0. The next access then starts again at slice 0.
- R2: An access to bus word address W produces exactly the port addresses (W-B)*RATIO+0 … (W-B)*RATIO+RATIO-1, in increasing order. Here B is the base word offset.
- R3: The write data of the k-th command is bus bits [k*PORT_DW +: PORT_DW], so the least significant slice goes first.
- R4: On a read, the word returned for the k-th command is placed at bus bits [k*PORT_DW +: PORT_DW] of `wb_dat_r`, and this value is valid while `wb_ack` is high.
- R5: `wb_ack` is high for exactly one cycle. It rises only after all RATIO command handshakes of the access have completed, and each access issues exactly RATIO commands.
- R6: While `cmd_ready` is low, `cmd_valid` stays high and the address and direction stay unchanged.
- R7: With byte masking enabled, the mask of the k-th command is `wb_sel[k*PORT_DW/8 +: PORT_DW/8]` (1 = write the byte). A masked-off byte is left unchanged in the memory.
- R8: The parameter `BASE_BYTES` is a byte address. B = BASE_BYTES / (BUS_DW/8) is subtracted from the bus word address before scaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | ADR_W | Bus word address |
| wb_dat_w | input | BUS_DW | Bus write data |
| wb_sel | input | BUS_DW/8 | Bus byte selects |
| wb_dat_r | output | BUS_DW | Assembled read data |
| wb_ack | output | 1 | Bus acknowledge |
| cmd_valid | output | 1 | Port command valid |
| cmd_ready | input | 1 | Port command accepted |
| cmd_we | output | 1 | Port command is a write |
| cmd_addr | output | ADR_W+log2(RATIO) | Port word address |
| cmd_wdata | output | PORT_DW | Port write slice |
| cmd_wmask | output | PORT_DW/8 | Port byte write mask |
| rd_valid | input | 1 | Port read data valid |
| rd_data | input | PORT_DW | Port read data |

## Verification
Two situations are hard to produce from the ports: a reset that lands part-way through a slice burst, and a port that stalls on a slice other than the first. To reach the first, the bench counts handshakes in its port model and raises reset right after the second one. To reach the second, it holds `cmd_ready` low for several cycles while a command is pending, and it also alternates a ready-every-third-cycle pattern between table entries. A byte-select write that touches only two slices, followed by a read-back, shows that masked-off bytes keep their old value.

// File: rtl/wbn_pkg.sv
package wbn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_WAIT_RD = 2'd2,
        ST_ACK     = 2'd3
    } seq_state_e;
endpackage

// File: rtl/wbn_addr_map.sv
// Removes the base word offset and scales the bus word address into port words.
module wbn_addr_map #(
    parameter int ADR_W      = 30,
    parameter int LOG_R      = 2,
    parameter int CNT_W      = 2,
    parameter int BASE_WORDS = 0
) (
    input  logic [ADR_W-1:0]       word_adr,
    input  logic [CNT_W-1:0]       slice,
    output logic [ADR_W+LOG_R-1:0] port_adr
);
    localparam int PADR_W = ADR_W + LOG_R;

    logic [ADR_W-1:0] rel_word;

    always_comb begin
        rel_word = word_adr - ADR_W'(BASE_WORDS);
        port_adr = (PADR_W'(rel_word) << LOG_R) | PADR_W'(slice);
    end
endmodule

// File: rtl/wbn_slicer.sv
// Selects the write slice and its byte mask for the current slice index.
module wbn_slicer #(
    parameter int BUS_DW    = 32,
    parameter int PORT_DW   = 8,
    parameter int RATIO     = 4,
    parameter int CNT_W     = 2,
    parameter bit BYTE_MASK = 1'b1
) (
    input  logic [BUS_DW-1:0]    wdata,
    input  logic [BUS_DW/8-1:0]  sel,
    input  logic [CNT_W-1:0]     slice,
    output logic [PORT_DW-1:0]   slice_data,
    output logic [PORT_DW/8-1:0] slice_mask
);
    localparam int PMW = PORT_DW / 8;

    logic [PORT_DW-1:0] parts [RATIO];
    logic [PMW-1:0]     masks [RATIO];

    for (genvar s = 0; s < RATIO; s++) begin : g_part
        assign parts[s] = wdata[s*PORT_DW +: PORT_DW];
        if (BYTE_MASK) begin : g_sel
            assign masks[s] = sel[s*PMW +: PMW];
        end else begin : g_full
            assign masks[s] = '1;
        end
    end

    assign slice_data = parts[slice];
    assign slice_mask = masks[slice];
endmodule

// File: rtl/wbn_assembler.sv
// Holding register: each returned port word is stored in its slice position.
module wbn_assembler #(
    parameter int BUS_DW  = 32,
    parameter int PORT_DW = 8,
    parameter int RATIO   = 4,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [CNT_W-1:0]   slice,
    input  logic [PORT_DW-1:0] rd_data,
    output logic [BUS_DW-1:0]  word
);
    for (genvar s = 0; s < RATIO; s++) begin : g_lane
        logic [PORT_DW-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
            end else if (capture && (slice == CNT_W'(s))) begin
                hold_q <= rd_data;
            end
        end

        assign word[s*PORT_DW +: PORT_DW] = hold_q;
    end
endmodule

// File: rtl/wbn_sequencer.sv
// Conversion state machine: latches a bus request and walks the slices.
module wbn_sequencer
    import wbn_pkg::*;
#(
    parameter int ADR_W  = 30,
    parameter int BUS_DW = 32,
    parameter int RATIO  = 4,
    parameter int CNT_W  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wb_cyc,
    input  logic                wb_stb,
    input  logic                wb_we,
    input  logic [ADR_W-1:0]    wb_adr,
    input  logic [BUS_DW-1:0]   wb_dat_w,
    input  logic [BUS_DW/8-1:0] wb_sel,
    input  logic                cmd_ready,
    input  logic                rd_valid,
    output logic                cmd_valid,
    output logic                cmd_we,
    output logic                wb_ack,
    output logic                capture,
    output logic [CNT_W-1:0]    slice,
    output logic [ADR_W-1:0]    req_adr,
    output logic [BUS_DW-1:0]   req_dat,
    output logic [BUS_DW/8-1:0] req_sel
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    seq_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic                we_q;
    logic [ADR_W-1:0]    adr_q;
    logic [BUS_DW-1:0]   dat_q;
    logic [BUS_DW/8-1:0] sel_q;
    logic                start;
    logic                last;

    assign start = wb_cyc && wb_stb;
    assign last  = (cnt_q == LAST);

    // State register and request/counter datapath.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            adr_q   <= '0;
            dat_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        we_q  <= wb_we;
                        adr_q <= wb_adr;
                        dat_q <= wb_dat_w;
                        sel_q <= wb_sel;
                        cnt_q <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready && we_q && !last) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT_RD: begin
                    if (rd_valid && !last) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ACK: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Transitions: start, next slice, write done, read issued, read next, read done, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (!we_q)     state_d = ST_WAIT_RD;
                    else if (last) state_d = ST_ACK;
                end
            end
            ST_WAIT_RD: begin
                if (rd_valid) state_d = last ? ST_ACK : ST_ISSUE;
            end
            ST_ACK: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        cmd_valid = (state_q == ST_ISSUE);
        wb_ack    = (state_q == ST_ACK);
        capture   = (state_q == ST_WAIT_RD) && rd_valid;
        cmd_we    = we_q;
        slice     = cnt_q;
        req_adr   = adr_q;
        req_dat   = dat_q;
        req_sel   = sel_q;
    end
endmodule

// File: rtl/wb_narrow_bridge.sv
// Wishbone slave to narrow memory command port width down-converter.
module wb_narrow_bridge #(
    parameter int          ADR_W      = 30,
    parameter int          BUS_DW     = 32,
    parameter int          PORT_DW    = 8,
    parameter int unsigned BASE_BYTES = 0,
    parameter bit          BYTE_MASK  = 1'b1,
    localparam int RATIO  = BUS_DW / PORT_DW,
    localparam int LOG_R  = $clog2(RATIO),
    localparam int PADR_W = ADR_W + LOG_R
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wb_cyc,
    input  logic                 wb_stb,
    input  logic                 wb_we,
    input  logic [ADR_W-1:0]     wb_adr,
    input  logic [BUS_DW-1:0]    wb_dat_w,
    input  logic [BUS_DW/8-1:0]  wb_sel,
    output logic [BUS_DW-1:0]    wb_dat_r,
    output logic                 wb_ack,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic                 cmd_we,
    output logic [PADR_W-1:0]    cmd_addr,
    output logic [PORT_DW-1:0]   cmd_wdata,
    output logic [PORT_DW/8-1:0] cmd_wmask,
    input  logic                 rd_valid,
    input  logic [PORT_DW-1:0]   rd_data
);
    localparam int CNT_W      = (LOG_R > 0) ? LOG_R : 1;
    localparam int BASE_WORDS = int'(BASE_BYTES / (BUS_DW / 8));

    if ((PORT_DW > BUS_DW) || (PORT_DW % 8 != 0) || (BUS_DW % PORT_DW != 0)
        || ((1 << LOG_R) != RATIO)) begin : g_bad_cfg
        $error("port width must be a whole-byte power-of-two fraction of the bus width");
    end

    logic                capture;
    logic [CNT_W-1:0]    slice;
    logic [ADR_W-1:0]    req_adr;
    logic [BUS_DW-1:0]   req_dat;
    logic [BUS_DW/8-1:0] req_sel;

    wbn_sequencer #(
        .ADR_W (ADR_W),
        .BUS_DW(BUS_DW),
        .RATIO (RATIO),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_w (wb_dat_w),
        .wb_sel   (wb_sel),
        .cmd_ready(cmd_ready),
        .rd_valid (rd_valid),
        .cmd_valid(cmd_valid),
        .cmd_we   (cmd_we),
        .wb_ack   (wb_ack),
        .capture  (capture),
        .slice    (slice),
        .req_adr  (req_adr),
        .req_dat  (req_dat),
        .req_sel  (req_sel)
    );

    wbn_addr_map #(
        .ADR_W     (ADR_W),
        .LOG_R     (LOG_R),
        .CNT_W     (CNT_W),
        .BASE_WORDS(BASE_WORDS)
    ) u_map (
        .word_adr(req_adr),
        .slice   (slice),
        .port_adr(cmd_addr)
    );

    wbn_slicer #(
        .BUS_DW   (BUS_DW),
        .PORT_DW  (PORT_DW),
        .RATIO    (RATIO),
        .CNT_W    (CNT_W),
        .BYTE_MASK(BYTE_MASK)
    ) u_slice (
        .wdata     (req_dat),
        .sel       (req_sel),
        .slice     (slice),
        .slice_data(cmd_wdata),
        .slice_mask(cmd_wmask)
    );

    wbn_assembler #(
        .BUS_DW (BUS_DW),
        .PORT_DW(PORT_DW),
        .RATIO  (RATIO),
        .CNT_W  (CNT_W)
    ) u_asm (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .slice  (slice),
        .rd_data(rd_data),
        .word   (wb_dat_r)
    );
endmodule

// File: rtl/wbn_checker.sv
// Protocol properties of the down-converter, bound to the top module.
module wbn_checker #(
    parameter int RATIO  = 4,
    parameter int PADR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wb_ack,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_we,
    input logic [PADR_W-1:0] cmd_addr
);
    logic [15:0]       hs_cnt;
    logic [PADR_W-1:0] prev_addr;
    logic              hs;

    assign hs = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_cnt    <= '0;
            prev_addr <= '0;
        end else begin
            if (wb_ack)  hs_cnt <= '0;
            else if (hs) hs_cnt <= hs_cnt + 16'd1;
            if (hs) prev_addr <= cmd_addr;
        end
    end

    // R5: acknowledge lasts a single cycle
    p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
        wb_ack |=> !wb_ack);

    // R5: acknowledge only after every slice handshake
    p_ack_count_r5: assert property (@(posedge clk) disable iff (rst)
        wb_ack |-> (hs_cnt == 16'(RATIO)));

    // R6: a stalled command keeps its content
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_we)));

    // R2: slices of one access go to consecutive port addresses
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (hs && hs_cnt != 16'd0) |-> (cmd_addr == prev_addr + PADR_W'(1)));
endmodule

bind wb_narrow_bridge wbn_checker #(
    .RATIO (RATIO),
    .PADR_W(PADR_W)
) u_wbn_chk (
    .clk      (clk),
    .rst      (rst),
    .wb_ack   (wb_ack),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_we   (cmd_we),
    .cmd_addr (cmd_addr)
);

// File: tb/wb_narrow_bridge_tb_top.sv
module wb_narrow_bridge_tb_top;
    localparam int ADR_W   = 30;
    localparam int BUS_DW  = 32;
    localparam int PORT_DW = 8;
    localparam int BASE_B  = 256;
    localparam int BASE_W  = BASE_B / (BUS_DW / 8);
    localparam int R       = BUS_DW / PORT_DW;
    localparam int PADR_W  = ADR_W + 2;
    localparam int NVEC    = 9;

    // vector: {we, adr[29:0], data[31:0], sel[3:0]}
    localparam logic [66:0] VEC [NVEC] = '{
        {1'b1, 30'h40, 32'h3C5A_0F81, 4'hF},
        {1'b1, 30'h45, 32'h9E17_D204, 4'hF},
        {1'b1, 30'h41, 32'h6B2C_7733, 4'hF},
        {1'b0, 30'h41, 32'h0,         4'hF},
        {1'b1, 30'h42, 32'hA1B2_C3D4, 4'h5},
        {1'b0, 30'h42, 32'h0,         4'hF},
        {1'b0, 30'h45, 32'h0,         4'hF},
        {1'b0, 30'h43, 32'h0,         4'hF},
        {1'b0, 30'h40, 32'h0,         4'hF}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [ADR_W-1:0]  wb_adr = '0;
    logic [31:0]       wb_dat_w = '0;
    logic [3:0]        wb_sel = '0;
    logic [31:0]       wb_dat_r;
    logic              wb_ack;
    logic              cmd_valid, cmd_we;
    logic              cmd_ready = 1'b0;
    logic [PADR_W-1:0] cmd_addr;
    logic [7:0]        cmd_wdata;
    logic [0:0]        cmd_wmask;
    logic              rd_valid = 1'b0;
    logic [7:0]        rd_data = '0;

    always #5 clk = ~clk;

    wb_narrow_bridge #(
        .ADR_W(ADR_W), .BUS_DW(BUS_DW), .PORT_DW(PORT_DW),
        .BASE_BYTES(BASE_B), .BYTE_MASK(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel),
        .wb_dat_r(wb_dat_r), .wb_ack(wb_ack), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_wmask(cmd_wmask),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    // Port memory model and handshake log.
    logic [7:0]        mem     [64];
    logic [7:0]        ref_mem [64];
    logic [PADR_W-1:0] hs_addr [16];
    logic [7:0]        hs_data [16];
    logic              hs_mask [16];
    int                hs_n = 0;
    int                stall_mode = 0;
    bit                hold_ready = 1'b0;
    int                rdy_ctr = 0;
    bit                pend_rd = 1'b0;
    logic [7:0]        pend_dat = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (rst) begin
            pend_rd   = 1'b0;
            cmd_ready = 1'b0;
        end else begin
            if (pend_rd) begin
                rd_valid = 1'b1;
                rd_data  = pend_dat;
                pend_rd  = 1'b0;
            end
            rdy_ctr++;
            if (hold_ready)           cmd_ready = 1'b0;
            else if (stall_mode == 1) cmd_ready = (rdy_ctr % 3 == 2);
            else                      cmd_ready = 1'b1;
            if (cmd_valid && cmd_ready) begin
                if (hs_n < 16) begin
                    hs_addr[hs_n] = cmd_addr;
                    hs_data[hs_n] = cmd_wdata;
                    hs_mask[hs_n] = cmd_wmask[0];
                end
                hs_n++;
                if (cmd_we) begin
                    if (cmd_wmask[0]) mem[cmd_addr[5:0]] = cmd_wdata;
                end else begin
                    pend_rd  = 1'b1;
                    pend_dat = mem[cmd_addr[5:0]];
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wb_access(input bit we, input logic [ADR_W-1:0] adr,
                             input logic [31:0] dat, input logic [3:0] sel,
                             output logic [31:0] rdat);
        @(negedge clk);
        hs_n     = 0;
        wb_cyc   = 1'b1;
        wb_stb   = 1'b1;
        wb_we    = we;
        wb_adr   = adr;
        wb_dat_w = dat;
        wb_sel   = sel;
        forever begin
            @(negedge clk);
            if (wb_ack) break;
        end
        rdat   = wb_dat_r;
        wb_cyc = 1'b0;
        wb_stb = 1'b0;
        @(negedge clk);
        check(wb_ack == 1'b0, "R5 ack one cycle", 64'(wb_ack), 64'd0);
    endtask

    task automatic check_hs(input logic [ADR_W-1:0] adr, input bit we,
                            input logic [31:0] dat, input logic [3:0] sel);
        check(hs_n == R, "R5 commands per access", 64'(hs_n), 64'(R));
        for (int k = 0; k < R && k < hs_n; k++) begin
            check(hs_addr[k] == PADR_W'((adr - ADR_W'(BASE_W)) * R + k),
                  "R2 R8 port address", 64'(hs_addr[k]),
                  64'((adr - ADR_W'(BASE_W)) * R + k));
            if (we) begin
                check(hs_data[k] == dat[k*8 +: 8], "R3 write slice",
                      64'(hs_data[k]), 64'(dat[k*8 +: 8]));
                check(hs_mask[k] == sel[k], "R7 slice mask",
                      64'(hs_mask[k]), 64'(sel[k]));
            end
        end
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] expw;
        logic [PADR_W-1:0] a0;
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'h00;
            ref_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        check(wb_ack == 1'b0 && cmd_valid == 1'b0, "R1 reset state",
              64'({wb_ack, cmd_valid}), 64'd0);
        rst = 1'b0;

        // Table walk, alternating port stall patterns.
        for (int i = 0; i < NVEC; i++) begin
            bit          we  = VEC[i][66];
            logic [29:0] adr = VEC[i][65:36];
            logic [31:0] dat = VEC[i][35:4];
            logic [3:0]  sel = VEC[i][3:0];
            stall_mode = i % 2;
            wb_access(we, adr, dat, sel, rd);
            check_hs(adr, we, dat, sel);
            if (we) begin
                for (int k = 0; k < R; k++)
                    if (sel[k]) ref_mem[(adr - BASE_W) * R + k] = dat[k*8 +: 8];
            end else begin
                for (int k = 0; k < R; k++) expw[k*8 +: 8] = ref_mem[(adr - BASE_W) * R + k];
                check(rd == expw, "R4 R7 read assembly", 64'(rd), 64'(expw));
            end
        end

        // R6: long stall on a pending command.
        stall_mode = 0;
        hold_ready = 1'b1;
        @(negedge clk);
        hs_n = 0;
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1;
        wb_adr = 30'h46; wb_dat_w = 32'h1357_9BDF; wb_sel = 4'hF;
        repeat (2) @(negedge clk);
        a0 = cmd_addr;
        repeat (4) @(negedge clk);
        check(cmd_valid == 1'b1 && cmd_addr == a0, "R6 stalled command held",
              64'(cmd_addr), 64'(a0));
        check(wb_ack == 1'b0, "R5 no ack while stalled", 64'(wb_ack), 64'd0);
        hold_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (wb_ack) break;
        end
        wb_cyc = 1'b0; wb_stb = 1'b0;
        @(negedge clk);
        check_hs(30'h46, 1'b1, 32'h1357_9BDF, 4'hF);

        // R1: reset in the middle of a slice burst.
        @(negedge clk);
        hs_n = 0;
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1;
        wb_adr = 30'h47; wb_dat_w = 32'h2468_ACE0; wb_sel = 4'hF;
        forever begin
            @(negedge clk);
            if (hs_n >= 2) break;
        end
        rst = 1'b1;
        wb_cyc = 1'b0; wb_stb = 1'b0;
        repeat (2) @(negedge clk);
        check(cmd_valid == 1'b0 && wb_ack == 1'b0, "R1 mid-sequence reset",
              64'({cmd_valid, wb_ack}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        wb_access(1'b1, 30'h47, 32'h2468_ACE0, 4'hF, rd);
        check(hs_addr[0] == PADR_W'((30'h47 - BASE_W) * R), "R1 restart at slice 0",
              64'(hs_addr[0]), 64'((30'h47 - BASE_W) * R));
        check_hs(30'h47, 1'b1, 32'h2468_ACE0, 4'hF);
        wb_access(1'b0, 30'h47, 32'h0, 4'hF, rd);
        check(rd == 32'h2468_ACE0, "R4 read after restart", 64'(rd), 64'h2468_ACE0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule